// File: doc/BRIEF.md
# Card Host Error Interrupt Status Block

This block keeps the error interrupt status of one channel of a memory-card host controller and drives that channel's single error interrupt line. Error pulses arrive from the command and data paths on a 16-bit event vector. A pulse latches into a sticky status bit when that bit's status enable is 1, and software clears a latched bit by writing a one to it at the status address.

A simple write port reaches four addresses: the status register (write ones to clear), the status enable register, the signal enable register, and a write-only force address. The force address holds no state. A one written there sets the matching status bit, gated by the status enable, as if a hardware error had occurred. This lets software test its error handlers without a real fault. A separate combinational read port returns the selected register.

The interrupt output is the registered OR, over all bits, of status AND status enable AND signal enable. It therefore follows a status change after one clock.

Top module: `err_irq_regs`

## Requirements
- R1: After reset, the status, status enable and signal enable registers all read 0 and `irq_o` is 0.
- R2: A write to the force address (`wr_addr` = 3) sets, on the next clock edge, every status bit where the written data is 1 and the status enable bit is 1. Bits written as 0 keep their value.
- R3: A force bit or event bit whose status enable bit is 0 leaves the status bit unchanged.
- R4: The force address stores nothing: a read at `rd_addr` = 3 always returns 0.
- R5: A 1 on `hw_err[i]` in a cycle sets status bit i on the next edge when status enable bit i is 1.
- R6: A write to the status address (`wr_addr` = 0) clears each status bit where the data is 1. Bits written as 0 are unchanged.
- R7: When a set (event or force) and a clear reach the same status bit in the same cycle, the bit ends up 1.
- R8: Bits 15 to 10 and bit 7 are reserved. They read 0 in the status, status enable and signal enable registers and are never set, whatever is written or signalled. The live mask is 0x037F.
- R9: `irq_o` equals the OR over all bits of (status AND status enable AND signal enable) as it was one clock earlier.
- R10: The bit positions, shared by `hw_err`, all registers and the force address, are: 0 command timeout, 1 command CRC, 2 command end bit, 3 command index, 4 data timeout, 5 data CRC, 6 data end bit, 8 automatic stop-command error, 9 descriptor DMA error. Address codes: 0 status, 1 status enable, 2 signal enable, 3 force.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 2 | Write address code (0 status, 1 status enable, 2 signal enable, 3 force) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address code, same encoding |
| rd_data | output | 16 | Read data for `rd_addr` (combinational) |
| hw_err | input | 16 | Error event pulses, one per status bit |
| irq_o | output | 1 | Registered error interrupt |

## Verification
On every cycle the assertions check four things: reserved bits stay 0, the interrupt output tracks the enabled status from one cycle earlier, every gated set lands (including when a clear arrives in the same cycle), and no status bit rises without an enabled cause. They also check that a clear without a set takes effect. The bench's scenarios are needed for the rest: that the force address reads back empty, that a zero written to the force or status address changes nothing, that the named error sources map to their bit positions, and that the interrupt falls again once an enable is withdrawn or the status is cleared.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;

    parameter int unsigned ERR_W = 16;
    localparam int unsigned SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_STAT  = 2'd0,
        SEL_STEN  = 2'd1,
        SEL_SIGEN = 2'd2,
        SEL_FORCE = 2'd3
    } sel_e;

    // bit positions of the error sources
    localparam int unsigned B_CMD_TMO   = 0;
    localparam int unsigned B_CMD_CRC   = 1;
    localparam int unsigned B_CMD_END   = 2;
    localparam int unsigned B_CMD_IDX   = 3;
    localparam int unsigned B_DAT_TMO   = 4;
    localparam int unsigned B_DAT_CRC   = 5;
    localparam int unsigned B_DAT_END   = 6;
    localparam int unsigned B_AUTO_STOP = 8;
    localparam int unsigned B_DESC_DMA  = 9;

    typedef logic [ERR_W-1:0] evec_t;

    function automatic evec_t build_live_mask();
        evec_t m;
        m = '0;
        m[B_CMD_TMO]   = 1'b1;
        m[B_CMD_CRC]   = 1'b1;
        m[B_CMD_END]   = 1'b1;
        m[B_CMD_IDX]   = 1'b1;
        m[B_DAT_TMO]   = 1'b1;
        m[B_DAT_CRC]   = 1'b1;
        m[B_DAT_END]   = 1'b1;
        m[B_AUTO_STOP] = 1'b1;
        m[B_DESC_DMA]  = 1'b1;
        return m;
    endfunction

    localparam evec_t LIVE_MASK = build_live_mask();

    typedef struct packed {
        evec_t val;
    } en_state_t;

    typedef struct packed {
        evec_t stat;
    } stat_state_t;

    typedef struct packed {
        logic irq;
    } irq_state_t;

endpackage

// File: rtl/err_irq_wr_dec.sv
module err_irq_wr_dec
    import err_irq_pkg::*;
(
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  evec_t            wr_data,
    output evec_t            force_vec,
    output evec_t            clr_vec,
    output logic             sten_we,
    output logic             sig_we
);
    sel_e sel;

    always_comb begin
        sel       = sel_e'(wr_addr);
        force_vec = '0;
        clr_vec   = '0;
        sten_we   = 1'b0;
        sig_we    = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_STAT:  clr_vec   = wr_data & LIVE_MASK;
                SEL_STEN:  sten_we   = 1'b1;
                SEL_SIGEN: sig_we    = 1'b1;
                SEL_FORCE: force_vec = wr_data & LIVE_MASK;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/err_irq_en_reg.sv
module err_irq_en_reg
    import err_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  evec_t din,
    output evec_t q
);
    en_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.val = din & LIVE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/err_irq_status.sv
module err_irq_status
    import err_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  evec_t hw_err,
    input  evec_t force_vec,
    input  evec_t clr_vec,
    input  evec_t sten,
    output evec_t stat
);
    stat_state_t st_d, st_q;
    evec_t       set_v;

    // per-bit set request: live bits only, gated by the status enable
    for (genvar g = 0; g < ERR_W; g++) begin : g_bit
        if (LIVE_MASK[g]) begin : g_live
            assign set_v[g] = (hw_err[g] | force_vec[g]) & sten[g];
        end else begin : g_rsvd
            assign set_v[g] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        // clear first, then set, so a set in the same cycle wins
        st_d.stat = ((st_q.stat & ~clr_vec) | set_v) & LIVE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
endmodule

// File: rtl/err_irq_out.sv
module err_irq_out
    import err_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  evec_t stat,
    input  evec_t sten,
    input  evec_t sig,
    output logic  irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = |(stat & sten & sig);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;
endmodule

// File: rtl/err_irq_regs.sv
module err_irq_regs
    import err_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_addr,
    input  logic [ERR_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_addr,
    output logic [ERR_W-1:0] rd_data,
    input  logic [ERR_W-1:0] hw_err,
    output logic             irq_o
);
    evec_t force_vec, clr_vec;
    logic  sten_we, sig_we;
    evec_t status_q, sten_q, sigen_q;

    err_irq_wr_dec u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .force_vec (force_vec),
        .clr_vec   (clr_vec),
        .sten_we   (sten_we),
        .sig_we    (sig_we)
    );

    err_irq_en_reg u_sten (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sten_we),
        .din   (wr_data),
        .q     (sten_q)
    );

    err_irq_en_reg u_sigen (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sig_we),
        .din   (wr_data),
        .q     (sigen_q)
    );

    err_irq_status u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_err    (hw_err),
        .force_vec (force_vec),
        .clr_vec   (clr_vec),
        .sten      (sten_q),
        .stat      (status_q)
    );

    err_irq_out u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .stat  (status_q),
        .sten  (sten_q),
        .sig   (sigen_q),
        .irq   (irq_o)
    );

    always_comb begin
        unique case (sel_e'(rd_addr))
            SEL_STAT:  rd_data = status_q;
            SEL_STEN:  rd_data = sten_q;
            SEL_SIGEN: rd_data = sigen_q;
            default:   rd_data = '0;   // force address holds no state
        endcase
    end
endmodule

// File: rtl/err_irq_chk.sv
module err_irq_chk
    import err_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_addr,
    input logic [ERR_W-1:0] wr_data,
    input logic [ERR_W-1:0] hw_err,
    input logic [ERR_W-1:0] status,
    input logic [ERR_W-1:0] sten,
    input logic [ERR_W-1:0] sigen,
    input logic [ERR_W-1:0] rd_data,
    input logic             irq_o
);
    logic [ERR_W-1:0] frc_c, clr_c, set_c;
    logic             any_c;

    assign frc_c = (wr_en && wr_addr == 2'd3) ? wr_data : '0;
    assign clr_c = (wr_en && wr_addr == 2'd0) ? wr_data : '0;
    assign set_c = (hw_err | frc_c) & sten & LIVE_MASK;
    assign any_c = |(status & sten & sigen);

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status | sten | sigen | rd_data) & ~LIVE_MASK) == '0);

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(any_c));

    // R7 (with R2, R5)
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & $past(set_c)) == $past(set_c));

    // R6
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & $past(clr_c & ~set_c)) == '0);

    // R3
    rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~$past(status) & ~$past(set_c)) == '0);
endmodule

bind err_irq_regs err_irq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .hw_err  (hw_err),
    .status  (status_q),
    .sten    (sten_q),
    .sigen   (sigen_q),
    .rd_data (rd_data),
    .irq_o   (irq_o)
);

// File: tb/tb_err_irq_regs.sv
`timescale 1ns/1ps
module tb_err_irq_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] hw_err = '0;
    logic        irq_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    err_irq_regs dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .hw_err(hw_err), .irq_o(irq_o)
    );

    // reference model, bit by bit
    logic [15:0] m_stat = '0, m_sten = '0, m_sig = '0;
    logic        m_irq = 1'b0;
    function automatic bit live(int i);
        return (i <= 6) || (i == 8) || (i == 9);   // R8, R10
    endfunction

    always @(posedge clk) begin
        logic [15:0] ns, nen, nsg;
        bit          any;
        ns = m_stat; nen = m_sten; nsg = m_sig; any = 0;
        for (int i = 0; i < 16; i++) begin
            bit s, c;
            any = any | (m_stat[i] & m_sten[i] & m_sig[i]);
            s = live(i) && m_sten[i] &&
                (hw_err[i] || (wr_en && wr_addr == 2'd3 && wr_data[i]));
            c = wr_en && wr_addr == 2'd0 && wr_data[i];
            if (c) ns[i] = 1'b0;
            if (s) ns[i] = 1'b1;
            if (wr_en && wr_addr == 2'd1) nen[i] = live(i) & wr_data[i];
            if (wr_en && wr_addr == 2'd2) nsg[i] = live(i) & wr_data[i];
        end
        if (!rst_n) begin
            m_stat <= '0; m_sten <= '0; m_sig <= '0; m_irq <= 1'b0;
        end else begin
            m_stat <= ns; m_sten <= nen; m_sig <= nsg; m_irq <= any;
        end
    end

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // compare against the model on every clock
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            logic [15:0] e;
            case (rd_addr)
                2'd0: e = m_stat;
                2'd1: e = m_sten;
                2'd2: e = m_sig;
                default: e = '0;
            endcase
            chk("R9 model irq", {15'd0, irq_o}, {15'd0, m_irq});
            chk("R2 model read", rd_data, e);
        end
    end

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse(logic [15:0] v);
        @(negedge clk); hw_err = v;
        @(negedge clk); hw_err = '0;
    endtask

    task automatic rd(string tag, logic [1:0] a, logic [15:0] exp);
        rd_addr = a; #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        rd("R1 status", 2'd0, 16'h0000);
        rd("R1 sten", 2'd1, 16'h0000);
        rd("R1 sigen", 2'd2, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'h0000);

        wr(2'd1, 16'hFFFF);
        rd("R8 sten reserved", 2'd1, 16'h037F);

        wr(2'd3, 16'h0002);
        rd("R2 R10 force cmd crc", 2'd0, 16'h0002);
        chk("R9 no irq without signal enable", {15'd0, irq_o}, 16'h0000);

        wr(2'd2, 16'h0002);
        step();
        chk("R9 irq raised", {15'd0, irq_o}, 16'h0001);
        rd("R8 sigen", 2'd2, 16'h0002);

        wr(2'd3, 16'h0000);
        rd("R2 zero force", 2'd0, 16'h0002);
        rd("R4 force reads zero", 2'd3, 16'h0000);

        wr(2'd3, 16'hFC80);
        rd("R8 reserved force", 2'd0, 16'h0002);

        wr(2'd1, 16'h0000);
        step();
        chk("R9 irq dropped by enable", {15'd0, irq_o}, 16'h0000);
        wr(2'd3, 16'h0010);
        rd("R3 force gated", 2'd0, 16'h0002);
        pulse(16'h0200);
        rd("R5 event gated", 2'd0, 16'h0002);

        wr(2'd1, 16'hFFFF);
        pulse(16'h0200);
        rd("R5 R10 event sets bit 9", 2'd0, 16'h0202);
        chk("R9 irq back", {15'd0, irq_o}, 16'h0001);

        wr(2'd0, 16'h0002);
        rd("R6 clear", 2'd0, 16'h0200);
        chk("R9 irq one cycle late", {15'd0, irq_o}, 16'h0001);
        step();
        chk("R9 irq after clear", {15'd0, irq_o}, 16'h0000);

        wr(2'd0, 16'h0000);
        rd("R6 zero clear", 2'd0, 16'h0200);

        @(negedge clk);
        hw_err = 16'h0010; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 16'h0210;
        @(negedge clk);
        hw_err = '0; wr_en = 1'b0; wr_data = '0;
        rd("R7 set wins", 2'd0, 16'h0010);

        pulse(16'h01FF);
        rd("R10 R8 all sources", 2'd0, 16'h017F);

        step();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule